// File: doc/BRIEF.md
# Colour Lookup Table with Sequenced Register Access

This block holds the colour lookup table of a display controller. It has 256 pixel entries and 4 overlay (cursor) entries, and each entry keeps an 8-bit red, an 8-bit green and an 8-bit blue value. Software reaches the table through a small window of 32-bit registers. It first loads an index. After that it streams the colour components one word at a time. A shared three-step phase counter chooses red, green or blue. After each completed triple the index moves on by one.

A second port serves the display pipeline. It takes any entry number and returns that entry's 24-bit colour in the same cycle, with no effect on the register-side state. Overlay entries are written through their own data offset, which uses the low two bits of the current index. This lets one index and one phase counter serve both kinds of entry.

Top module: `pal_dac`

## Requirements
- R1: After reset every entry reads as black (0x000000) except entries 255, 256 and 258, which are white (0xFFFFFF); the index is 0 and the phase is red.
- R2: A write to byte offset 0 loads the index from wdata bits 31:24 and returns the phase to red, so the next data access addresses red of that entry.
- R3: Writes to byte offset 4 store wdata bits 31:24 into red, then green, then blue of pixel entry `index`; after the blue write the index advances by one and the phase returns to red.
- R4: Writes to byte offset 12 store into overlay entry 256 + index[1:0] with the same red/green/blue sequence, and the index still advances after blue.
- R5: Writes to any offset other than 0, 4 and 12 change no entry, no index and no phase.
- R6: A read returns the current component of pixel entry `index` in bits 31:24 with bits 23:0 zero, steps the phase red, green, blue, and advances the index after blue; rdata is zero when no read is requested.
- R7: The index wraps from 255 to 0 when it advances, for both reads and writes.
- R8: The display port returns {red, green, blue} (red in bits 23:16) of entry disp_idx in the same cycle for entries 0 to 259, and 0 for any larger number.
- R9: Reads and writes share one phase counter, so a read that follows a red write returns green, and a write that follows that read stores blue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access, never together with bus_wr |
| bus_addr | input | 4 | Byte offset inside the register window |
| bus_wdata | input | 32 | Write data; the colour byte or index sits in bits 31:24 |
| bus_rdata | output | 32 | Read data, valid in the cycle bus_rd is high |
| disp_idx | input | 9 | Entry number requested by the display path |
| disp_rgb | output | 24 | Colour of entry disp_idx, red in the top byte |

## Verification
The table is loaded with distinct byte values per component. This shows whether red, green and blue land in their own lanes and whether the index advances only after blue. Overlay loads start from an index whose upper bits are non-zero, so using the full index instead of the low two bits would show up. The index is also placed at 255 so the wrap to 0 can be seen. Reads and writes are mixed within one triple to expose separate phase counters, and writes to unused offsets are followed by a normal load to show that neither phase nor index moved.

// File: rtl/pal_pkg.sv
package pal_pkg;
    typedef enum logic [1:0] {
        PH_RED  = 2'd0,
        PH_GRN  = 2'd1,
        PH_BLU  = 2'd2,
        PH_IDLE = 2'd3
    } phase_e;

    localparam logic [3:0] OFF_INDEX   = 4'd0;
    localparam logic [3:0] OFF_PIXEL   = 4'd4;
    localparam logic [3:0] OFF_OVERLAY = 4'd12;
endpackage

// File: rtl/pal_seq.sv
module pal_seq
    import pal_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int OVL_W  = 2,
    parameter int DATA_W = 32,
    localparam int ENT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             rd,
    input  logic [3:0]       addr,
    input  logic [IDX_W-1:0] wtop,
    output logic [IDX_W-1:0] idx_q_o,
    output phase_e           phase_q_o,
    output logic             st_en,
    output logic [ENT_W-1:0] st_entry
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        phase_e           phase;
    } seq_t;

    seq_t st_d, st_q;
    logic data_wr, ovl_wr;

    always_comb begin
        st_d     = st_q;
        st_en    = 1'b0;
        ovl_wr   = wr && (addr == OFF_OVERLAY);
        data_wr  = wr && ((addr == OFF_PIXEL) || ovl_wr);
        st_entry = ovl_wr ? {1'b1, {(IDX_W-OVL_W){1'b0}}, st_q.idx[OVL_W-1:0]}
                          : {1'b0, st_q.idx};
        if (wr && (addr == OFF_INDEX)) begin
            st_d.idx   = wtop;
            st_d.phase = PH_RED;
        end else if (data_wr || rd) begin
            if (st_q.phase == PH_IDLE) begin
                st_d.phase = PH_RED;
            end else begin
                st_en = data_wr;
                if (st_q.phase == PH_BLU) begin
                    st_d.phase = PH_RED;
                    st_d.idx   = st_q.idx + 1'b1;
                end else begin
                    st_d.phase = phase_e'(st_q.phase + 2'd1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.idx   <= '0;
            st_q.phase <= PH_RED;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_q_o   = st_q.idx;
    assign phase_q_o = st_q.phase;

    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase != PH_IDLE); // R3
    AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFF_INDEX) |=> (st_q.idx == $past(wtop)) && (st_q.phase == PH_RED)); // R2
    AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (((wr && (addr == OFF_PIXEL || addr == OFF_OVERLAY)) || rd) && st_q.phase == PH_BLU)
        |=> st_q.idx == $past(st_q.idx) + 1'b1); // R7
    AST_IGNORED_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr != OFF_INDEX && addr != OFF_PIXEL && addr != OFF_OVERLAY)
        |=> $stable(st_q.idx) && $stable(st_q.phase)); // R5
    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && rd)); // R6
endmodule

// File: rtl/pal_store.sv
module pal_store
    import pal_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int OVL_N  = 4,
    parameter int COMP_W = 8,
    localparam int ENT_W  = IDX_W + 1,
    localparam int NPIX   = 1 << IDX_W,
    localparam int NENT   = NPIX + OVL_N,
    localparam int RGB_W  = 3 * COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ENT_W-1:0]  w_entry,
    input  phase_e            w_phase,
    input  logic [COMP_W-1:0] w_byte,
    input  logic [ENT_W-1:0]  ra_entry,
    output logic [RGB_W-1:0]  ra_rgb,
    input  logic [ENT_W-1:0]  rb_entry,
    output logic [RGB_W-1:0]  rb_rgb
);
    logic [RGB_W-1:0] mem_d [NENT];
    logic [RGB_W-1:0] mem_q [NENT];

    function automatic logic [RGB_W-1:0] boot_colour(input int e);
        if (e == NPIX - 1 || e == NPIX || e == NPIX + 2) return '1;
        return '0;
    endfunction

    always_comb begin
        for (int i = 0; i < NENT; i++) mem_d[i] = mem_q[i];
        if (we && (int'(w_entry) < NENT)) begin
            case (w_phase)
                PH_RED:  mem_d[w_entry][3*COMP_W-1 -: COMP_W] = w_byte;
                PH_GRN:  mem_d[w_entry][2*COMP_W-1 -: COMP_W] = w_byte;
                PH_BLU:  mem_d[w_entry][COMP_W-1   -: COMP_W] = w_byte;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NENT; i++) mem_q[i] <= boot_colour(i);
        end else begin
            for (int i = 0; i < NENT; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign ra_rgb = (int'(ra_entry) < NENT) ? mem_q[ra_entry] : '0;
    assign rb_rgb = (int'(rb_entry) < NENT) ? mem_q[rb_entry] : '0;

    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> int'(w_entry) < NENT); // R4
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && w_phase == PH_RED && int'(w_entry) < NENT)
        |=> mem_q[$past(w_entry)][3*COMP_W-1 -: COMP_W] == $past(w_byte)); // R3
endmodule

// File: rtl/pal_dac.sv
module pal_dac
    import pal_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int OVL_N  = 4,
    parameter int COMP_W = 8,
    parameter int DATA_W = 32,
    localparam int OVL_W = $clog2(OVL_N),
    localparam int ENT_W = IDX_W + 1,
    localparam int RGB_W = 3 * COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [3:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [ENT_W-1:0]  disp_idx,
    output logic [RGB_W-1:0]  disp_rgb
);
    logic [IDX_W-1:0] idx_q;
    phase_e           phase_q;
    logic             st_en;
    logic [ENT_W-1:0] st_entry;
    logic [RGB_W-1:0] bus_rgb;
    logic [COMP_W-1:0] comp_sel;
    logic [DATA_W-COMP_W-1:0] unused_low;

    assign unused_low = bus_wdata[DATA_W-COMP_W-1:0];

    pal_seq #(.IDX_W(IDX_W), .OVL_W(OVL_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .addr      (bus_addr),
        .wtop      (bus_wdata[DATA_W-1 -: IDX_W]),
        .idx_q_o   (idx_q),
        .phase_q_o (phase_q),
        .st_en     (st_en),
        .st_entry  (st_entry)
    );

    pal_store #(.IDX_W(IDX_W), .OVL_N(OVL_N), .COMP_W(COMP_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (st_en),
        .w_entry  (st_entry),
        .w_phase  (phase_q),
        .w_byte   (bus_wdata[DATA_W-1 -: COMP_W]),
        .ra_entry ({1'b0, idx_q}),
        .ra_rgb   (bus_rgb),
        .rb_entry (disp_idx),
        .rb_rgb   (disp_rgb)
    );

    always_comb begin
        case (phase_q)
            PH_RED:  comp_sel = bus_rgb[3*COMP_W-1 -: COMP_W];
            PH_GRN:  comp_sel = bus_rgb[2*COMP_W-1 -: COMP_W];
            PH_BLU:  comp_sel = bus_rgb[COMP_W-1   -: COMP_W];
            default: comp_sel = '0;
        endcase
        bus_rdata = bus_rd ? {comp_sel, {(DATA_W-COMP_W){1'b0}}} : '0;
    end

    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == '0); // R6
endmodule

// File: tb/pal_dac_tb.sv
module pal_dac_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [8:0]  disp_idx = '0;
    logic [23:0] disp_rgb;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pal_dac u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .disp_idx(disp_idx), .disp_rgb(disp_rgb)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] b);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = {b, 24'h5A5A5A};
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic look(input string req, input int e, input logic [23:0] exp);
        disp_idx = 9'(e);
        #1 check(req, {8'h0, disp_rgb}, {8'h0, exp});
    endtask

    task automatic t_reset();
        logic [31:0] d;
        look("R1", 0, 24'h000000);
        look("R1", 254, 24'h000000);
        look("R1", 255, 24'hFFFFFF);
        look("R1", 256, 24'hFFFFFF);
        look("R1", 257, 24'h000000);
        look("R1", 258, 24'hFFFFFF);
        look("R1", 259, 24'h000000);
        @(negedge clk);
        #1 check("R6 idle rdata", bus_rdata, 32'h0);
        rd(d); check("R1 index 0 red", d, 32'h0);
    endtask

    task automatic t_pixel();
        logic [31:0] d;
        wr(4'd0, 8'd5);
        wr(4'd4, 8'h11); wr(4'd4, 8'h22); wr(4'd4, 8'h33);
        look("R3", 5, 24'h112233);
        wr(4'd4, 8'h44); wr(4'd4, 8'h55); wr(4'd4, 8'h66);
        look("R3 next entry", 6, 24'h445566);
        wr(4'd0, 8'd5);
        rd(d); check("R6 red", d, 32'h11000000);
        rd(d); check("R6 green", d, 32'h22000000);
        rd(d); check("R6 blue", d, 32'h33000000);
        rd(d); check("R6 advance", d, 32'h44000000);
    endtask

    task automatic t_overlay();
        wr(4'd0, 8'h0A);
        wr(4'd12, 8'h01); wr(4'd12, 8'h02); wr(4'd12, 8'h03);
        look("R4 ovl 2", 258, 24'h010203);
        look("R4 pixel untouched", 10, 24'h000000);
        wr(4'd12, 8'h07); wr(4'd12, 8'h08); wr(4'd12, 8'h09);
        look("R4 ovl 3", 259, 24'h070809);
        look("R4 ovl 0", 256, 24'hFFFFFF);
    endtask

    task automatic t_ignored();
        wr(4'd0, 8'd7);
        wr(4'd8, 8'hEE); wr(4'd1, 8'hDD); wr(4'd15, 8'hCC);
        look("R5 no store", 7, 24'h000000);
        wr(4'd4, 8'hA1); wr(4'd4, 8'hA2); wr(4'd4, 8'hA3);
        look("R5 phase/index kept", 7, 24'hA1A2A3);
        look("R5 neighbour", 8, 24'h000000);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        wr(4'd0, 8'hFF);
        wr(4'd4, 8'hB1); wr(4'd4, 8'hB2); wr(4'd4, 8'hB3);
        look("R7 entry 255", 255, 24'hB1B2B3);
        wr(4'd4, 8'hC1); wr(4'd4, 8'hC2); wr(4'd4, 8'hC3);
        look("R7 wrapped to 0", 0, 24'hC1C2C3);
        wr(4'd0, 8'hFF);
        rd(d); rd(d); rd(d);
        rd(d); check("R7 read wrap", d, 32'hC1000000);
    endtask

    task automatic t_shared();
        logic [31:0] d;
        wr(4'd0, 8'd20);
        wr(4'd4, 8'h9A);
        rd(d); check("R9 read after red write", d, 32'h00000000);
        wr(4'd4, 8'h5C);
        look("R9 blue after read", 20, 24'h9A005C);
        wr(4'd4, 8'h3E);
        look("R9 index advanced", 21, 24'h3E0000);
    endtask

    task automatic t_reload();
        wr(4'd0, 8'd30);
        wr(4'd4, 8'h77);
        wr(4'd0, 8'd30);
        wr(4'd4, 8'h88);
        look("R2 phase reset", 30, 24'h880000);
        wr(4'd4, 8'h99);
        look("R2 green next", 30, 24'h889900);
    endtask

    task automatic t_oob();
        look("R8 beyond table", 260, 24'h0);
        look("R8 max", 511, 24'h0);
        look("R8 in range", 6, 24'h445566);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pixel();
        t_overlay();
        t_ignored();
        t_wrap();
        t_shared();
        t_reload();
        t_oob();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule